// File: doc/BRIEF.md
# Four-Function Integer Arithmetic Unit

This block is a purely combinational arithmetic unit. It takes two unsigned operand words and a three-bit operation code. In the same cycle it returns one result word and three flags: a carry/borrow indication, a division-by-zero indication and an indication that the operation code is not defined. Four operations are defined: sum, difference, product and quotient. The difference is formed on the same adder that forms the sum, by feeding it the inverted second operand and a carry-in of one. The product and the quotient each have their own unit.

The surrounding logic is expected to register the operands and the code, and to capture the result and flags at the next clock edge. The data width is a parameter with a default of 16 bits. The code field stays at three bits for any width. Codes 100 through 111 are unassigned and are reported as undefined.

Top module: `alu4_core`

## Requirements
- R1: With code 000, the result is (A + B) modulo 2^W and the carry flag is the carry out of bit W-1.
- R2: With code 010, the result is (A - B) modulo 2^W, and the carry flag is 1 exactly when A < B as unsigned numbers (borrow).
- R3: With code 001, the result is the low W bits of the unsigned product A * B, and the carry flag is 0.
- R4: With code 011 and B non-zero, the result is the unsigned quotient floor(A / B), and the carry flag is 0.
- R5: With code 011 and B equal to zero, the division-by-zero flag is 1 and the result is all ones; the carry flag is 0.
- R6: With any code from 100 to 111, the undefined-code flag is 1, the result is 0, and both the carry and division-by-zero flags are 0.
- R7: The undefined-code flag is 0 for codes 000 to 011. The division-by-zero flag is 0 for every code other than 011, including when B is zero.
- R8: Every output is a function of the present inputs only; a change of inputs is visible on the outputs before the next clock edge, with no state carried between operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | W | First operand, unsigned |
| opb_i | input | W | Second operand, unsigned (addend, subtrahend, multiplier or divisor) |
| op_i | input | 3 | Operation code: 000 sum, 001 product, 010 difference, 011 quotient |
| res_o | output | W | Result word |
| cy_o | output | 1 | Carry out for sum, borrow for difference, 0 otherwise |
| dz_o | output | 1 | Division by zero was requested |
| bad_o | output | 1 | Operation code is undefined |

## Verification
The hardest cases to reach are the edges of the quotient unit, where a restoring step sits on the boundary of its trial subtraction. These are a divisor of one, a divisor larger than the dividend, a dividend equal to the divisor, a full-scale dividend with a full-scale divisor, and a divisor of zero. Uniform random operands almost never produce them. The stimulus therefore walks a directed list of these operand pairs under every code, then adds the borrow boundary A = B and A = B - 1. It then continues with random words whose divisor is drawn from a narrow range, so that quotients span many magnitudes.

// File: rtl/alu4_pkg.sv
`timescale 1ns/1ps
package alu4_pkg;

    localparam int OP_BITS = 3;

    typedef enum logic [OP_BITS-1:0] {
        OP_SUM  = 3'b000,
        OP_PROD = 3'b001,
        OP_DIFF = 3'b010,
        OP_QUOT = 3'b011
    } alu_op_e;

endpackage

// File: rtl/alu4_addsub.sv
`timescale 1ns/1ps
module alu4_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         neg_i,
    output logic [W-1:0] sum_o,
    output logic         flag_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff  = neg_i ? ~b_i : b_i;
        wide   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, neg_i};
        sum_o  = wide[W-1:0];
        // for a difference, a missing carry out means a borrow
        flag_o = neg_i ? ~wide[W] : wide[W];
    end
endmodule

// File: rtl/alu4_mul.sv
`timescale 1ns/1ps
module alu4_mul #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] prod_o
);
    logic [W-1:0] acc;

    // shift-and-add; only the low W bits are kept
    always_comb begin
        acc = '0;
        for (int i = 0; i < W; i++) begin
            if (b_i[i]) acc = acc + (a_i << i);
        end
        prod_o = acc;
    end
endmodule

// File: rtl/alu4_div.sv
`timescale 1ns/1ps
module alu4_div #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] quot_o
);
    logic [W-1:0] rem;
    logic [W:0]   trial;
    logic [W:0]   diff;
    logic [W-1:0] q;

    // restoring division, one quotient bit per step, MSB first
    always_comb begin
        rem = '0;
        q   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            trial = {rem, a_i[i]};
            diff  = trial - {1'b0, b_i};
            q[i]  = ~diff[W];
            rem   = diff[W] ? trial[W-1:0] : diff[W-1:0];
        end
        quot_o = q;
    end
endmodule

// File: rtl/alu4_core.sv
`timescale 1ns/1ps
module alu4_core
    import alu4_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]       opa_i,
    input  logic [W-1:0]       opb_i,
    input  logic [OP_BITS-1:0] op_i,
    output logic [W-1:0]       res_o,
    output logic               cy_o,
    output logic               dz_o,
    output logic               bad_o
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] res;
        logic         cy;
        logic         dz;
        logic         bad;
    } alu_out_t;

    logic [W-1:0] as_sum, mul_prod, div_quot;
    logic         as_flag;
    logic         is_diff;
    alu_out_t     out_d;

    assign is_diff = (op_i == OP_DIFF);

    alu4_addsub #(.W(W)) u_addsub (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .neg_i  (is_diff),
        .sum_o  (as_sum),
        .flag_o (as_flag)
    );

    alu4_mul #(.W(W)) u_mul (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .prod_o (mul_prod)
    );

    alu4_div #(.W(W)) u_div (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .quot_o (div_quot)
    );

    always_comb begin
        out_d = '0;
        case (op_i)
            OP_SUM,
            OP_DIFF: begin
                out_d.res = as_sum;
                out_d.cy  = as_flag;
            end
            OP_PROD: out_d.res = mul_prod;
            OP_QUOT: begin
                if (opb_i == '0) begin
                    out_d.dz  = 1'b1;
                    out_d.res = ALL_ONES;
                end else begin
                    out_d.res = div_quot;
                end
            end
            default: out_d.bad = 1'b1;
        endcase
    end

    assign res_o = out_d.res;
    assign cy_o  = out_d.cy;
    assign dz_o  = out_d.dz;
    assign bad_o = out_d.bad;

    always_comb begin
        AST_UNDEF_QUIET: assert (!bad_o || (res_o == '0 && !cy_o && !dz_o))
            else $error("undefined code produced data"); // R6
        AST_DZ_ONES: assert (!dz_o || res_o == ALL_ONES)
            else $error("divide by zero result not all ones"); // R5
        AST_FLAGS_EXCL: assert (!(bad_o && dz_o))
            else $error("both flags set"); // R7
        AST_BORROW_CMP: assert (!(op_i == OP_DIFF) || (cy_o == (opa_i < opb_i)))
            else $error("borrow disagrees with compare"); // R2
        AST_NOCARRY_MD: assert (!(op_i == OP_PROD || op_i == OP_QUOT) || !cy_o)
            else $error("carry set on product or quotient"); // R3
        AST_QUOT_BOUND: assert (!(op_i == OP_QUOT && opb_i != '0) || res_o <= opa_i)
            else $error("quotient exceeds dividend"); // R4
    end
endmodule

// File: tb/alu4_core_tb.sv
`timescale 1ns/1ps
module alu4_core_tb;
    localparam int W = 16;
    localparam longint unsigned MASK = (64'd1 << W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;   // 125 MHz

    logic [W-1:0] opa, opb, res;
    logic [2:0]   op;
    logic         cy, dz, bad;

    int n_cmp = 0;
    int n_bad = 0;

    alu4_core #(.W(W)) u_dut (
        .opa_i (opa),
        .opb_i (opb),
        .op_i  (op),
        .res_o (res),
        .cy_o  (cy),
        .dz_o  (dz),
        .bad_o (bad)
    );

    // behavioural reference
    task automatic expect_of(input longint unsigned a, input longint unsigned b,
                             input int code, output longint unsigned r,
                             output bit c, output bit z, output bit u);
        r = 0; c = 0; z = 0; u = 0;
        case (code)
            0: begin r = (a + b) & MASK; c = ((a + b) >> W) != 0; end
            1: r = (a * b) & MASK;
            2: begin r = (a - b) & MASK; c = (a < b); end
            3: if (b == 0) begin r = MASK; z = 1; end else r = a / b;
            default: u = 1;
        endcase
    endtask

    function automatic string tag_of(input int code, input longint unsigned b);
        case (code)
            0: return "R1";
            1: return "R3";
            2: return "R2";
            3: return (b == 0) ? "R5" : "R4";
            default: return "R6";
        endcase
    endfunction

    // drive on falling edge, compare at the next rising edge
    task automatic run(input longint unsigned a, input longint unsigned b, input int code);
        longint unsigned er;
        bit ec, ez, eu;
        @(negedge clk);
        opa = W'(a); opb = W'(b); op = 3'(code);
        expect_of(a, b, code, er, ec, ez, eu);
        @(posedge clk);
        n_cmp++;
        if (res !== W'(er) || cy !== ec || dz !== ez || bad !== eu) begin
            n_bad++;
            $display("FAIL %s/R7/R8 op=%0d a=%h b=%h actual res=%h cy=%b dz=%b bad=%b expected res=%h cy=%b dz=%b bad=%b",
                     tag_of(code, b), code, a, b, res, cy, dz, bad, W'(er), ec, ez, eu);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        longint unsigned edges [8];
        opa = '0; opb = '0; op = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: zero inputs give zero sum, no flags (R1, R7)
        @(posedge clk);
        n_cmp++;
        if (res !== '0 || cy !== 1'b0 || dz !== 1'b0 || bad !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 idle actual res=%h cy=%b dz=%b bad=%b expected 0 0 0 0", res, cy, dz, bad);
        end
        edges[0] = 0; edges[1] = 1; edges[2] = 2; edges[3] = 7;
        edges[4] = 16'h8000; edges[5] = 16'h7FFF; edges[6] = 16'hFFFE; edges[7] = 16'hFFFF;
        // every code over the corner operands, including B = 0 for non-divide (R7)
        for (int c = 0; c < 8; c++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    run(edges[i], edges[j], c);
        run(16'hFFFF, 16'h0001, 0);   // R1 carry out
        run(16'h0005, 16'h0005, 2);   // R2 equal, no borrow
        run(16'h0004, 16'h0005, 2);   // R2 borrow
        run(16'h0100, 16'h0100, 1);   // R3 truncation
        run(16'd100, 16'd7, 3);       // R4
        run(16'd6, 16'd7, 3);         // R4 divisor above dividend
        run(16'h1234, 16'h0000, 3);   // R5
        run(16'h1234, 16'h0000, 1);   // R7 no dz on product
        // R8: back-to-back changes, one operation per cycle
        for (int k = 0; k < 3000; k++) begin
            longint unsigned a = longint'($urandom) & MASK;
            longint unsigned b = (k % 2 == 0) ? (longint'($urandom) & MASK)
                                              : (longint'($urandom_range(0, 40)));
            run(a, b, int'($urandom_range(0, 7)));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule